// File: doc/BRIEF.md
# Password-Gated Pin Lock Guard

This unit protects the per-pin configuration of a multi-bank general-purpose I/O controller. Each bank of 32 pins owns a 32-bit lock register; a set bit freezes the matching pin. Software changes a lock register in two steps. It first writes a fixed key value to the key register, which arms the unit. The very next register write, if it targets a bank lock register, loads that register. Any other write in between, or a wrong key value, drops the arming. Lock registers can be read back, so software can change a single pin's bit with a read-modify-write.

Every register write on the controller passes through the unit. Writes to the key and lock registers stop here. Writes to a pin's control word are forwarded only when that pin is unlocked. Writes to a bank's output set or clear register are forwarded with the bits of locked pins forced to zero. All other writes pass through unchanged in the same cycle. The full lock state also leaves the unit as a flat vector, for other gating in the controller.

Top module: `pin_lock_guard`

## Requirements
- R1: After reset every lock bit is 1. `rd_data` is 0 and `fwd_wr_en` is 0 until stimulus arrives.
- R2: A write to the bank lock register at byte offset 0x500 + 4*b (b < NBANK) loads `wdata` only if the immediately preceding write was the value 0x00A5A501 to offset 0x520.
- R3: A lock register write with no preceding key write leaves the register unchanged.
- R4: The key arms exactly one following write. A key write with any other value, or any other write in between, disarms the unit, and a later lock write is then ignored.
- R5: When `rd_en` is high, `rd_data` on the next cycle holds the lock register at `rd_addr`. Other offsets read as 0. Reads do not change the arming.
- R6: A write to the control word at 0x100 + 4*p (p < 32*NBANK) is forwarded only when lock bit p%32 of bank p/32 is 0.
- R7: A write to a bank's set register (0x040 + 4*b) or clear register (0x060 + 4*b) is forwarded in the same cycle, with `wdata` bits of locked pins cleared.
- R8: Key and lock register writes are never forwarded. Writes to any other offset are forwarded unchanged in the same cycle.
- R9: `lock_vec` bit 32*b + i equals bit i of bank b's lock register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Write byte offset |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 32 | Read data, one cycle after `rd_en` |
| lock_vec | output | 32*NBANK | Flat per-pin lock state |
| fwd_wr_en | output | 1 | Forwarded write strobe |
| fwd_addr | output | 12 | Forwarded write offset |
| fwd_wdata | output | 32 | Forwarded write data, masked for set/clear writes |

## Verification
Directed sequences try the key followed directly by a lock write, the key with a wrong value, the key followed by an unrelated write, a lock write with no key at all, and two lock writes after a single key. Together these separate one-shot arming from sticky arming and from a check on the address alone. Control and set/clear writes are sent against banks with mixed lock patterns. This shows whether gating uses the right bank and bit, and whether masking is applied instead of blocking the whole write. A seeded random mix of key, lock, control, set/clear, unrelated writes and reads, including occasional wrong keys, is then compared against a bench model of the arming and of every lock register.

// File: rtl/plg_pkg.sv
package plg_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 12;
  localparam logic [DW-1:0] KEY_VALUE = 32'h00A5_A501;
  localparam logic [AW-1:0] KEY_OFF  = 12'h520;
  localparam logic [AW-1:0] LOCK_OFF = 12'h500;
  localparam logic [AW-1:0] CTRL_OFF = 12'h100;
  localparam logic [AW-1:0] SET_OFF  = 12'h040;
  localparam logic [AW-1:0] CLR_OFF  = 12'h060;

  // word-aligned offset inside a window of n words starting at base
  function automatic logic in_window(logic [AW-1:0] a, logic [AW-1:0] base, int unsigned n);
    int unsigned ai, bi;
    ai = int'(a);
    bi = int'(base);
    return (a[1:0] == 2'b00) && (ai >= bi) && (ai < bi + 4 * n);
  endfunction

  function automatic int unsigned word_index(logic [AW-1:0] a, logic [AW-1:0] base);
    return (int'(a) - int'(base)) >> 2;
  endfunction

  function automatic logic is_key_write(logic [AW-1:0] a, logic [DW-1:0] d);
    return (a == KEY_OFF) && (d == KEY_VALUE);
  endfunction
endpackage

// File: rtl/plg_arm.sv
module plg_arm
  import plg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wdata,
  output logic          armed
);
  logic key_seen;
  assign key_seen = wr_en && is_key_write(wr_addr, wdata);

  // every write re-decides arming; reads leave it alone
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed <= 1'b0;
    else if (wr_en) armed <= key_seen;
  end

  p_arm_from_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(wr_en && wr_addr == KEY_OFF && wdata == KEY_VALUE));

  p_arm_one_shot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_en && wr_addr != KEY_OFF) |=> !armed);
endmodule

// File: rtl/plg_lock_regs.sv
module plg_lock_regs
  import plg_pkg::*;
#(
  parameter int unsigned NBANK = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                armed,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wdata,
  input  logic                rd_en,
  input  logic [AW-1:0]       rd_addr,
  output logic [DW-1:0]       rd_data,
  output logic [NBANK*DW-1:0] lock_vec
);
  logic [DW-1:0] lock_q   [NBANK];
  logic [NBANK-1:0] hit;
  logic [NBANK-1:0] load_ev;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [AW-1:0] OFF = LOCK_OFF + AW'(4 * b);
    assign hit[b]     = wr_en && (wr_addr == OFF);
    assign load_ev[b] = hit[b] && armed;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lock_q[b] <= '1;
      else if (load_ev[b]) lock_q[b] <= wdata;
    end

    assign lock_vec[b*DW +: DW] = lock_q[b];

    p_unarmed_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[b] && !armed) |=> $stable(lock_q[b]));

    p_armed_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load_ev[b] |=> (lock_q[b] == $past(wdata)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) begin
      if (in_window(rd_addr, LOCK_OFF, NBANK))
        rd_data <= lock_q[word_index(rd_addr, LOCK_OFF)];
      else
        rd_data <= '0;
    end
  end
endmodule

// File: rtl/plg_write_gate.sv
module plg_write_gate
  import plg_pkg::*;
#(
  parameter int unsigned NBANK = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NBANK*DW-1:0] lock_vec,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wdata,
  output logic                fwd_wr_en,
  output logic [AW-1:0]       fwd_addr,
  output logic [DW-1:0]       fwd_wdata
);
  localparam int unsigned NPIN = NBANK * DW;

  logic is_ctrl, is_set, is_clr, is_own;
  logic pin_locked;
  logic [DW-1:0] bank_mask;

  assign is_ctrl = in_window(wr_addr, CTRL_OFF, NPIN);
  assign is_set  = in_window(wr_addr, SET_OFF, NBANK);
  assign is_clr  = in_window(wr_addr, CLR_OFF, NBANK);
  assign is_own  = (wr_addr == KEY_OFF) || in_window(wr_addr, LOCK_OFF, NBANK);

  always_comb begin
    pin_locked = 1'b0;
    bank_mask  = '0;
    if (is_ctrl) pin_locked = lock_vec[word_index(wr_addr, CTRL_OFF)];
    if (is_set)  bank_mask  = lock_vec[word_index(wr_addr, SET_OFF) * DW +: DW];
    if (is_clr)  bank_mask  = lock_vec[word_index(wr_addr, CLR_OFF) * DW +: DW];
  end

  assign fwd_wr_en = wr_en && !is_own && !(is_ctrl && pin_locked);
  assign fwd_addr  = wr_addr;
  assign fwd_wdata = wdata & ~bank_mask;

  p_ctrl_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_ctrl && pin_locked) |-> !fwd_wr_en);

  p_setclr_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_wr_en && (is_set || is_clr)) |-> ((fwd_wdata & bank_mask) == '0));

  p_own_consumed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_own) |-> !fwd_wr_en);
endmodule

// File: rtl/pin_lock_guard.sv
module pin_lock_guard
  import plg_pkg::*;
#(
  parameter int unsigned NBANK = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [11:0]         wr_addr,
  input  logic [31:0]         wdata,
  input  logic                rd_en,
  input  logic [11:0]         rd_addr,
  output logic [31:0]         rd_data,
  output logic [NBANK*32-1:0] lock_vec,
  output logic                fwd_wr_en,
  output logic [11:0]         fwd_addr,
  output logic [31:0]         fwd_wdata
);
  logic armed;

  plg_arm u_arm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wdata(wdata), .armed(armed)
  );

  plg_lock_regs #(.NBANK(NBANK)) u_regs (
    .clk(clk), .rst_n(rst_n), .armed(armed), .wr_en(wr_en),
    .wr_addr(wr_addr), .wdata(wdata), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .lock_vec(lock_vec)
  );

  plg_write_gate #(.NBANK(NBANK)) u_gate (
    .clk(clk), .rst_n(rst_n), .lock_vec(lock_vec), .wr_en(wr_en),
    .wr_addr(wr_addr), .wdata(wdata), .fwd_wr_en(fwd_wr_en),
    .fwd_addr(fwd_addr), .fwd_wdata(fwd_wdata)
  );

  p_reset_locked_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (lock_vec == '1));
endmodule

// File: tb/sim_pin_lock_guard.sv
module sim_pin_lock_guard;
  localparam int NB = 4;
  localparam logic [31:0] KEY = 32'h00A5_A501;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [NB*32-1:0] lock_vec;
  logic fwd_wr_en;
  logic [11:0] fwd_addr;
  logic [31:0] fwd_wdata;

  int checks = 0, errors = 0;
  logic arm_m = 1'b0;
  logic [31:0] lk_m [NB];

  always #4 clk = ~clk;

  pin_lock_guard #(.NBANK(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .lock_vec(lock_vec),
    .fwd_wr_en(fwd_wr_en), .fwd_addr(fwd_addr), .fwd_wdata(fwd_wdata)
  );

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected forward for a write, from the requirement text (R6, R7, R8)
  function automatic logic [32:0] exp_fwd(logic [11:0] a, logic [31:0] d);
    int ai = int'(a);
    if (a == 12'h520) return {1'b0, d};
    if (a[1:0] == 0 && ai >= 'h500 && ai < 'h500 + 4*NB) return {1'b0, d};
    if (a[1:0] == 0 && ai >= 'h100 && ai < 'h100 + 4*32*NB) begin
      int p = (ai - 'h100) / 4;
      return {~lk_m[p/32][p%32], d};
    end
    if (a[1:0] == 0 && ai >= 'h40 && ai < 'h40 + 4*NB) return {1'b1, d & ~lk_m[(ai-'h40)/4]};
    if (a[1:0] == 0 && ai >= 'h60 && ai < 'h60 + 4*NB) return {1'b1, d & ~lk_m[(ai-'h60)/4]};
    return {1'b1, d};
  endfunction

  task automatic do_wr(string req, logic [11:0] a, logic [31:0] d);
    logic [32:0] e;
    int ai = int'(a);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wdata = d;
    #1;
    e = exp_fwd(a, d);
    check({req, " R8 fwd_en"}, 128'(fwd_wr_en), 128'(e[32]));
    if (e[32]) begin
      check({req, " R7 fwd_data"}, 128'(fwd_wdata), 128'(e[31:0]));
      check({req, " R8 fwd_addr"}, 128'(fwd_addr), 128'(a));
    end
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    if (a[1:0] == 0 && ai >= 'h500 && ai < 'h500 + 4*NB && arm_m)
      lk_m[(ai - 'h500) / 4] = d;
    arm_m = (a == 12'h520) && (d == KEY);
  endtask

  task automatic do_rd(string req, logic [11:0] a);
    logic [31:0] e;
    int ai = int'(a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    e = (a[1:0] == 0 && ai >= 'h500 && ai < 'h500 + 4*NB) ? lk_m[(ai - 'h500) / 4] : 32'h0;
    check({req, " R5 read"}, 128'(rd_data), 128'(e));
  endtask

  task automatic chk_vec(string req);
    for (int b = 0; b < NB; b++)
      check({req, " R9 lock_vec"}, 128'(lock_vec[b*32 +: 32]), 128'(lk_m[b]));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < NB; b++) lk_m[b] = '1;
    #1;
    check("R1 fwd idle", 128'(fwd_wr_en), 128'(0));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R1 lock reset", 128'(lock_vec), {128{1'b1}});
    check("R1 rd_data reset", 128'(rd_data), 128'(0));

    // R3: lock write without key is ignored
    do_wr("R3 unarmed", 12'h504, 32'h0);
    do_rd("R3", 12'h504);
    // R2: key then lock write
    do_wr("R2 key", 12'h520, KEY);
    do_wr("R2 load", 12'h504, 32'h0000_00F0);
    do_rd("R2", 12'h504);
    // R4: arming is one-shot
    do_wr("R4 second", 12'h504, 32'h0);
    do_rd("R4 one-shot", 12'h504);
    // R4: wrong key
    do_wr("R4 badkey", 12'h520, KEY ^ 32'h1);
    do_wr("R4 after bad", 12'h500, 32'h0);
    do_rd("R4 bad key", 12'h500);
    // R4: intervening write
    do_wr("R4 key", 12'h520, KEY);
    do_wr("R4 other", 12'h200, 32'h5);
    do_wr("R4 late", 12'h508, 32'h0);
    do_rd("R4 intervening", 12'h508);
    // R5: read between key and lock write does not disarm
    do_wr("R5 key", 12'h520, KEY);
    do_rd("R5 mid", 12'h500);
    do_wr("R5 load", 12'h500, 32'h0);
    do_rd("R5 after", 12'h500);
    do_rd("R5 other addr", 12'h520);
    // R6: control words, bank 1 pins 4..7 locked, bank 0 open
    do_wr("R6 open pin", 12'h100 + 12'(4*3), 32'h1);
    do_wr("R6 locked pin", 12'h100 + 12'(4*(32+4)), 32'h1);
    do_wr("R6 open b1", 12'h100 + 12'(4*(32+8)), 32'h1);
    // R7: set/clear masking
    do_wr("R7 set b1", 12'h044, 32'hFFFF_FFFF);
    do_wr("R7 clr b2", 12'h068, 32'h1234_5678);
    do_wr("R7 set b0", 12'h040, 32'hDEAD_BEEF);
    // R8: unrelated passes
    do_wr("R8 misc", 12'h7F0, 32'hCAFE_0001);
    chk_vec("R9 directed");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 6);
      int b  = $urandom_range(0, NB - 1);
      logic [31:0] d = $urandom();
      case (op)
        0: do_wr("R2 rnd key", 12'h520, ($urandom_range(0, 3) == 0) ? d : KEY);
        1: do_wr("R2 rnd lock", 12'h500 + 12'(4*b), d);
        2: do_wr("R6 rnd ctrl", 12'h100 + 12'(4*$urandom_range(0, 32*NB - 1)), d);
        3: do_wr("R7 rnd set", 12'h040 + 12'(4*b), d);
        4: do_wr("R7 rnd clr", 12'h060 + 12'(4*b), d);
        5: do_rd("R5 rnd", 12'h500 + 12'(4*b));
        default: do_wr("R8 rnd misc", 12'h600 + 12'(4*$urandom_range(0, 63)), d);
      endcase
    end
    chk_vec("R9 final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule